// File: doc/BRIEF.md
# Service Result ASCII Register Block

This block sits between a soft controller on an APB bus and the sequencer that runs device information services. The controller writes a selection code to a start register, which launches one of three services: fetching the 128-bit serial number, fetching the 16-bit design version, or running the on-chip memory digest check. The controller then polls a status word until the run completes.

When the sequencer returns a result, the block converts each 4-bit nibble into its ASCII hexadecimal character. It stores the characters in a word-addressed array, one character per 32-bit word, with the most significant nibble first. The controller can copy each byte straight into a UART transmit register without doing any conversion itself.

A small state machine has four states. IDLE is the state after reset. LAUNCH lasts one cycle and pulses the service start. WAIT waits for the result strobe. DONE holds the completed result. The transitions are:

- IDLE→LAUNCH and DONE→LAUNCH on an accepted start write.
- LAUNCH→WAIT unconditionally.
- WAIT→DONE on the result strobe.

Top module: `apb_svc_ascii_regs`

## Requirements
- R1: After reset, the start register and status word read 0, every character slot reads 0x00, and `svc_start` is low.
- R2: A write of 1, 2 or 3 to offset 0x00 while not busy is accepted. Codes: 1 = serial number, 2 = design version, 3 = memory digest. Acceptance moves the machine to LAUNCH. `svc_start` is high for exactly the one following cycle, with `svc_sel` equal to the code. Busy is set, and done and error are cleared. Any other value, or any start write while busy, is ignored.
- R3: Nibbles 0–9 become 0x30–0x39 and nibbles A–F become uppercase 0x41–0x46.
- R4: A serial number result fills all 32 slots. The slot at offset 0x40+4*i holds nibble i counted from bits [127:124] downward.
- R5: A version result fills slots 0–3 from bits [15:0], most significant nibble first, and clears slots 4–31 to 0x00. A version of zero reads "0000".
- R6: A digest result writes the 8-bit response byte as two characters in slots 0–1 and clears the rest. A response of 0 reads "00" and leaves the error bit clear.
- R7: The result strobe is taken only in WAIT. It moves the machine to DONE, sets done, and sets error exactly when the response byte is nonzero. Done stays set until the next accepted start.
- R8: A result strobe in IDLE, LAUNCH or DONE changes neither the characters nor the flags.
- R9: The status word at 0x04 carries busy in bit 0, done in bit 1 and error in bit 2. Offset 0x00 reads back the last accepted code in bits [1:0].
- R10: PREADY is always high and PSLVERR always low. Reads of offsets outside 0x00, 0x04 and 0x40–0xBC return 0. Writes to any offset other than 0x00 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error, always low |
| svc_start | output | 1 | One-cycle service launch pulse |
| svc_sel | output | 2 | Selected service code |
| res_valid | input | 1 | Result strobe from the sequencer |
| res_data | input | SER_BITS | Result payload; the version uses the low VER_BITS |
| res_status | input | STS_BITS | Response byte; nonzero means error or digest mismatch |

## Verification
The bench builds the block with its default parameters:

- a 128-bit serial number,
- a 16-bit version,
- an 8-bit response,
- an 8-bit address,
- the character base at 0x40.

This places the last character slot at 0xBC and the first unmapped word at 0xC0, both inside the address space. A version result leaves 28 slots that must read as cleared, so the clearing of stale characters after a longer serial result can be observed. A behavioural model tracks the busy, done, error and launch flags and the character array every cycle. It is checked against the launch pulse on every clock and against every APB read. This includes strobes that arrive during LAUNCH or DONE and start writes that arrive while busy.

// File: rtl/svc_ascii_pkg.sv
package svc_ascii_pkg;

    typedef enum logic [1:0] {
        SVC_NONE    = 2'd0,
        SVC_SERIAL  = 2'd1,
        SVC_VERSION = 2'd2,
        SVC_DIGEST  = 2'd3
    } svc_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_WAIT,
        ST_DONE
    } fsm_state_e;

    localparam int STAT_BUSY_BIT = 0;
    localparam int STAT_DONE_BIT = 1;
    localparam int STAT_ERR_BIT  = 2;

    // Hex nibble to uppercase ASCII character.
    function automatic logic [7:0] nib_to_ascii(input logic [3:0] nib);
        if (nib < 4'd10) begin
            return 8'h30 + {4'h0, nib};
        end
        return 8'h37 + {4'h0, nib};
    endfunction

endpackage

// File: rtl/svc_ascii_fsm.sv
module svc_ascii_fsm
    import svc_ascii_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_req,
    input  svc_sel_e start_sel,
    input  logic     res_valid,
    input  logic     res_err,
    output logic     busy,
    output logic     done,
    output logic     err,
    output logic     svc_start,
    output logic     capture,
    output svc_sel_e cur_sel
);

    fsm_state_e state_q;
    fsm_state_e state_d;
    logic       accept;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_req) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_WAIT;
            ST_WAIT:   if (res_valid) state_d = ST_DONE;
            ST_DONE:   if (start_req) state_d = ST_LAUNCH;
        endcase
    end

    // Outputs.
    always_comb begin
        busy      = 1'b0;
        done      = 1'b0;
        svc_start = 1'b0;
        capture   = 1'b0;
        accept    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                accept = start_req;
            end
            ST_LAUNCH: begin
                busy      = 1'b1;
                svc_start = 1'b1;
            end
            ST_WAIT: begin
                busy    = 1'b1;
                capture = res_valid;
            end
            ST_DONE: begin
                done   = 1'b1;
                accept = start_req;
            end
        endcase
    end

    // Selection and error flag.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_sel <= SVC_NONE;
            err     <= 1'b0;
        end else if (accept) begin
            cur_sel <= start_sel;
            err     <= 1'b0;
        end else if (capture) begin
            err <= res_err;
        end
    end

endmodule

// File: rtl/svc_ascii_store.sv
module svc_ascii_store
    import svc_ascii_pkg::*;
#(
    parameter int SER_BITS = 128,
    parameter int VER_BITS = 16,
    parameter int STS_BITS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  svc_sel_e                     sel,
    input  logic [SER_BITS-1:0]          res_data,
    input  logic [STS_BITS-1:0]          res_status,
    output logic [SER_BITS/4-1:0][7:0]   chars
);

    localparam int NCHARS    = SER_BITS / 4;
    localparam int VER_CHARS = VER_BITS / 4;
    localparam int STS_CHARS = STS_BITS / 4;

    for (genvar i = 0; i < NCHARS; i++) begin : g_char
        logic [7:0] ser_c;
        logic [7:0] ver_c;
        logic [7:0] sts_c;
        logic [7:0] nxt_c;
        logic [7:0] ch_q;

        assign ser_c = nib_to_ascii(res_data[SER_BITS-1-4*i -: 4]);

        if (i < VER_CHARS) begin : g_ver
            assign ver_c = nib_to_ascii(res_data[VER_BITS-1-4*i -: 4]);
        end else begin : g_nover
            assign ver_c = 8'h00;
        end

        if (i < STS_CHARS) begin : g_sts
            assign sts_c = nib_to_ascii(res_status[STS_BITS-1-4*i -: 4]);
        end else begin : g_nosts
            assign sts_c = 8'h00;
        end

        always_comb begin
            unique case (sel)
                SVC_SERIAL:  nxt_c = ser_c;
                SVC_VERSION: nxt_c = ver_c;
                SVC_DIGEST:  nxt_c = sts_c;
                default:     nxt_c = 8'h00;
            endcase
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_q <= 8'h00;
            end else if (load) begin
                ch_q <= nxt_c;
            end
        end

        assign chars[i] = ch_q;
    end

endmodule

// File: rtl/apb_svc_ascii_regs.sv
module apb_svc_ascii_regs
    import svc_ascii_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SER_BITS  = 128,
    parameter int VER_BITS  = 16,
    parameter int STS_BITS  = 8,
    parameter int CHAR_BASE = 'h40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                psel,
    input  logic                penable,
    input  logic                pwrite,
    input  logic [ADDR_W-1:0]   paddr,
    input  logic [31:0]         pwdata,
    output logic [31:0]         prdata,
    output logic                pready,
    output logic                pslverr,
    output logic                svc_start,
    output logic [1:0]          svc_sel,
    input  logic                res_valid,
    input  logic [SER_BITS-1:0] res_data,
    input  logic [STS_BITS-1:0] res_status
);

    localparam int WORD_W     = ADDR_W - 2;
    localparam int NCHARS     = SER_BITS / 4;
    localparam int IDX_W      = $clog2(NCHARS);
    localparam int CHAR_WORD0 = CHAR_BASE / 4;
    localparam logic [WORD_W-1:0] START_WORD = '0;
    localparam logic [WORD_W-1:0] STAT_WORD  = WORD_W'(1);

    logic [WORD_W-1:0]          word;
    logic [WORD_W-1:0]          rel;
    logic [IDX_W-1:0]           idx;
    logic                       in_chars;
    logic                       wr_access;
    logic                       start_req;
    logic                       busy;
    logic                       done;
    logic                       err;
    logic                       capture;
    svc_sel_e                   cur_sel;
    logic [NCHARS-1:0][7:0]     chars;
    logic                       unused_addr_lsb;

    assign word            = paddr[ADDR_W-1:2];
    assign unused_addr_lsb = ^paddr[1:0];
    assign wr_access       = psel && penable && pwrite;
    assign start_req       = wr_access && (word == START_WORD) &&
                             (pwdata >= 32'd1) && (pwdata <= 32'd3);

    svc_ascii_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .start_sel (svc_sel_e'(pwdata[1:0])),
        .res_valid (res_valid),
        .res_err   (|res_status),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .svc_start (svc_start),
        .capture   (capture),
        .cur_sel   (cur_sel)
    );

    svc_ascii_store #(
        .SER_BITS (SER_BITS),
        .VER_BITS (VER_BITS),
        .STS_BITS (STS_BITS)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (capture),
        .sel        (cur_sel),
        .res_data   (res_data),
        .res_status (res_status),
        .chars      (chars)
    );

    assign svc_sel = cur_sel;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    // Read decode.
    assign rel      = word - WORD_W'(CHAR_WORD0);
    assign idx      = rel[IDX_W-1:0];
    assign in_chars = (word >= WORD_W'(CHAR_WORD0)) && (rel < WORD_W'(NCHARS));

    always_comb begin
        prdata = '0;
        if (word == START_WORD) begin
            prdata[1:0] = cur_sel;
        end else if (word == STAT_WORD) begin
            prdata[STAT_BUSY_BIT] = busy;
            prdata[STAT_DONE_BIT] = done;
            prdata[STAT_ERR_BIT]  = err;
        end else if (in_chars) begin
            prdata[7:0] = chars[idx];
        end
    end

endmodule

// File: rtl/svc_ascii_chk.sv
module svc_ascii_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              psel,
    input logic              penable,
    input logic              pwrite,
    input logic [ADDR_W-1:0] paddr,
    input logic [31:0]       pwdata,
    input logic              pready,
    input logic              pslverr,
    input logic              svc_start,
    input logic              busy,
    input logic              done,
    input logic              res_valid
);

    logic start_wr;
    logic start_ok;

    assign start_wr = psel && penable && pwrite && (paddr[ADDR_W-1:2] == '0);
    assign start_ok = start_wr && (pwdata >= 32'd1) && (pwdata <= 32'd3) && !busy;

    // R2: launch pulse lasts one cycle
    a_r2_start_single: assert property (@(posedge clk) disable iff (!rst_n)
        svc_start |=> !svc_start);

    // R2: accepted start write launches next cycle
    a_r2_start_follows: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> svc_start && busy && !done);

    // R2: start write while busy is ignored
    a_r2_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (start_wr && busy) |=> !svc_start);

    // R7: busy and done never together
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R7: strobe while waiting completes the run
    a_r7_capture_done: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !svc_start && res_valid) |=> done && !busy);

    // R7: done is sticky until a new start
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start_ok) |=> done);

    // R8: strobe during the launch cycle does not complete
    a_r8_launch_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        svc_start |=> busy);

    // R10: bus response fixed
    a_r10_bus_resp: assert property (@(posedge clk) disable iff (!rst_n)
        pready && !pslverr);

endmodule

bind apb_svc_ascii_regs svc_ascii_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .pready    (pready),
    .pslverr   (pslverr),
    .svc_start (svc_start),
    .busy      (busy),
    .done      (done),
    .res_valid (res_valid)
);

// File: tb/apb_svc_ascii_regs_tb.sv
module apb_svc_ascii_regs_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         psel = 1'b0;
    logic         penable = 1'b0;
    logic         pwrite = 1'b0;
    logic [7:0]   paddr = '0;
    logic [31:0]  pwdata = '0;
    logic [31:0]  prdata;
    logic         pready;
    logic         pslverr;
    logic         svc_start;
    logic [1:0]   svc_sel;
    logic         res_valid = 1'b0;
    logic [127:0] res_data = '0;
    logic [7:0]   res_status = '0;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    apb_svc_ascii_regs u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .psel       (psel),
        .penable    (penable),
        .pwrite     (pwrite),
        .paddr      (paddr),
        .pwdata     (pwdata),
        .prdata     (prdata),
        .pready     (pready),
        .pslverr    (pslverr),
        .svc_start  (svc_start),
        .svc_sel    (svc_sel),
        .res_valid  (res_valid),
        .res_data   (res_data),
        .res_status (res_status)
    );

    // Behavioural reference model
    bit         m_busy = 0;
    bit         m_done = 0;
    bit         m_err = 0;
    bit         m_launch = 0;
    logic [1:0] m_sel = 2'd0;
    logic [7:0] m_ch [32];

    function automatic logic [7:0] asc(input logic [3:0] n);
        if (n <= 4'd9) return 8'd48 + 8'(n);
        return 8'd65 + 8'(n - 4'd10);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_err = 0; m_launch = 0; m_sel = 2'd0;
            for (int i = 0; i < 32; i++) m_ch[i] = 8'h00;
        end else begin
            automatic bit acc = psel && penable && pwrite && (paddr[7:2] == 6'd0) &&
                                (pwdata >= 1) && (pwdata <= 3) && !m_busy;
            if (m_launch) begin
                m_launch = 0;
            end else if (m_busy && res_valid) begin
                m_busy = 0;
                m_done = 1;
                m_err  = (res_status != 8'h00);
                for (int i = 0; i < 32; i++) m_ch[i] = 8'h00;
                if (m_sel == 2'd1) begin
                    for (int i = 0; i < 32; i++) m_ch[i] = asc(res_data[127-4*i -: 4]);
                end else if (m_sel == 2'd2) begin
                    for (int i = 0; i < 4; i++) m_ch[i] = asc(res_data[15-4*i -: 4]);
                end else if (m_sel == 2'd3) begin
                    for (int i = 0; i < 2; i++) m_ch[i] = asc(res_status[7-4*i -: 4]);
                end
            end
            if (acc) begin
                m_busy = 1; m_launch = 1; m_done = 0; m_err = 0;
                m_sel = pwdata[1:0];
            end
        end
    end

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        automatic int w = int'(a[7:2]);
        if (w == 0) return {30'd0, m_sel};
        if (w == 1) return {29'd0, m_err, m_done, m_busy};
        if (w >= 16 && w < 48) return {24'd0, m_ch[w-16]};
        return 32'd0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison of the launch interface (R2)
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2 launch pulse", {31'd0, svc_start}, {31'd0, m_launch});
            if (m_launch) chk("R2 launch code", {30'd0, svc_sel}, {30'd0, m_sel});
        end
    end

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input string tag, input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk);
        penable = 1'b1;
        #2;
        d = prdata;
        chk({tag, " model"}, prdata, exp_read(a));
        chk("R10 pready/pslverr", {30'd0, pready, pslverr}, 32'd2);
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_lit(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] d;
        apb_rd(tag, a, d);
        chk(tag, d, exp);
    endtask

    task automatic pulse_res(input logic [127:0] d, input logic [7:0] s);
        res_valid = 1'b1; res_data = d; res_status = s;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic run_svc(input logic [31:0] code, input logic [127:0] d,
                           input logic [7:0] s, input int dly);
        apb_wr(8'h00, code);
        repeat (dly) @(negedge clk);
        pulse_res(d, s);
        @(negedge clk);
    endtask

    task automatic finish_sim();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_lit("R1 start reg", 8'h00, 32'h0);
        rd_lit("R1 status", 8'h04, 32'h0);
        rd_lit("R1 char0", 8'h40, 32'h0);
        rd_lit("R1 char31", 8'hBC, 32'h0);

        // R5: default version reads "0000"
        run_svc(32'd2, 128'h0, 8'h00, 2);
        rd_lit("R7 done after version", 8'h04, 32'h2);
        for (int i = 0; i < 4; i++) rd_lit("R5 version zero", 8'(8'h40 + 4*i), 32'h30);
        rd_lit("R5 slot4 clear", 8'h50, 32'h0);
        rd_lit("R9 start readback", 8'h00, 32'h2);

        // R4 / R3: serial number, all 32 slots
        run_svc(32'd1, 128'h0123456789ABCDEF_FEDCBA9876543210, 8'h00, 3);
        for (int i = 0; i < 32; i++) apb_rd("R4 serial char", 8'(8'h40 + 4*i), d);
        rd_lit("R3 digit 0", 8'h40, 32'h30);
        rd_lit("R3 digit 9", 8'h64, 32'h39);
        rd_lit("R3 letter A", 8'h68, 32'h41);
        rd_lit("R3 letter F", 8'h7C, 32'h46);
        rd_lit("R4 last char", 8'hBC, 32'h30);

        // R5: shorter result clears stale slots
        run_svc(32'd2, 128'hFFFF_0000_0000_0000_0000_0000_0000_A5F1, 8'h7F, 1);
        rd_lit("R5 ver c0", 8'h40, 32'h41);
        rd_lit("R5 ver c1", 8'h44, 32'h35);
        rd_lit("R5 ver c2", 8'h48, 32'h46);
        rd_lit("R5 ver c3", 8'h4C, 32'h31);
        rd_lit("R5 stale cleared", 8'hBC, 32'h0);
        rd_lit("R7 error set", 8'h04, 32'h6);

        // R6: digest pass and mismatch
        run_svc(32'd3, 128'h0, 8'h00, 2);
        rd_lit("R6 pass c0", 8'h40, 32'h30);
        rd_lit("R6 pass c1", 8'h44, 32'h30);
        rd_lit("R6 pass status", 8'h04, 32'h2);
        run_svc(32'd3, 128'h0, 8'h02, 2);
        rd_lit("R6 mismatch c1", 8'h44, 32'h32);
        rd_lit("R7 mismatch status", 8'h04, 32'h6);

        // R2: bad selection values ignored
        apb_wr(8'h00, 32'd0);
        apb_wr(8'h00, 32'd4);
        apb_wr(8'h00, 32'h101);
        rd_lit("R2 bad code ignored status", 8'h04, 32'h6);
        rd_lit("R2 bad code ignored sel", 8'h00, 32'h3);

        // R8: strobe in DONE ignored
        pulse_res(128'hDEAD, 8'h00);
        rd_lit("R8 done strobe chars", 8'h44, 32'h32);
        rd_lit("R8 done strobe flags", 8'h04, 32'h6);

        // R8: strobe during LAUNCH ignored; R2: start while busy ignored
        apb_wr(8'h00, 32'd1);
        pulse_res(128'h1, 8'h00);
        rd_lit("R8 launch strobe busy", 8'h04, 32'h1);
        apb_wr(8'h00, 32'd3);
        rd_lit("R2 busy start ignored", 8'h00, 32'h1);
        rd_lit("R8 chars kept", 8'h44, 32'h32);
        pulse_res(128'hFEDC_BA98_7654_3210_0123_4567_89AB_CDEF, 8'h00);
        rd_lit("R7 completes", 8'h04, 32'h2);
        rd_lit("R4 serial c0", 8'h40, 32'h46);
        rd_lit("R4 serial c31", 8'hBC, 32'h46);

        // R10: unmapped and non-start writes
        apb_wr(8'h04, 32'hFFFF_FFFF);
        apb_wr(8'h40, 32'h0000_0055);
        apb_wr(8'h10, 32'd1);
        rd_lit("R10 status unchanged", 8'h04, 32'h2);
        rd_lit("R10 char unchanged", 8'h40, 32'h46);
        rd_lit("R10 unmapped 08", 8'h08, 32'h0);
        rd_lit("R10 unmapped 3C", 8'h3C, 32'h0);
        rd_lit("R10 unmapped C0", 8'hC0, 32'h0);
        rd_lit("R10 unmapped FC", 8'hFC, 32'h0);

        repeat (3) @(negedge clk);
        finish_sim();
    end

endmodule